// File: doc/BRIEF.md
# Smart Card Power Sequencer

This controller brings the contacts of an inserted smart card up and down in a fixed order. Activation starts on a falling edge of the host's active-low command. It powers the card supply first, checks a supply-valid comparator, releases the I/O line into reception, starts the card clock, and then lets the card reset follow the host's reset request. The card reset can rise only after a minimum number of card clock cycles have reached the card.

Deactivation starts when the host raises its command, when the card is removed, or when a fault occurs. The lines then go down in the opposite order: reset, clock, I/O, supply. A discharge window follows before another activation can be accepted. All intervals are counted in ticks of a timebase input, and each interval length is a parameter. The supply and the comparator are outside the block.

Top module: `sc_power_seq`

## Requirements
- R1: After reset, and on the cycle after a `pwr_event` pulse, all card outputs are low and the fault latch is clear. Command edges are ignored until HOLD_TICKS timebase ticks have been counted.
- R2: Activation is accepted only in idle, only on a falling edge of `host_cmd_n` (high in the previous cycle, low now), and only while `fault_n` is high. A command held low gives no activation. `vcc_en` goes high on the clock edge that accepts the activation.
- R3: Counting ticks from acceptance, `io_rx` goes to 1 (reception) at tick T1+T2. The clock gate request is set at tick T1+T2+T3. The active state is reached at tick T1+T2+T3+T4.
- R4: At tick T1 of activation, if `vcc_good` is low, `vcc_en` falls and `fault_n` goes low on the same edge, and deactivation begins.
- R5: In the active state, `card_rst` follows `host_rst_req`. It stays low until CLK_MIN_CYCLES rising edges of `card_clk` have passed through the open gate.
- R6: The gate on `card_clk_out` opens or closes only on an edge where `card_clk` is low. `card_clk_out` equals `card_clk` while the gate is open and is 0 otherwise.
- R7: During any activation stage or the active state, `host_cmd_n` high or `fault_n` low starts deactivation at once. Any remaining activation stages are abandoned.
- R8: Counting ticks from the start of deactivation, `card_rst` falls at tick DR. The clock gate request drops at tick DR+DC. `io_rx` (0 = held low) and `vcc_en` fall at tick DR+DC+DI.
- R9: Command edges are ignored until DISCH_TICKS ticks after deactivation began. Only then does the block return to idle.
- R10: `fault_n` equals `card_ok` AND NOT the fault latch. The latch is cleared while idle with `host_cmd_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick, one clock wide |
| pwr_event | input | 1 | Supply rise or power-down exit; restarts the hold-off |
| card_clk | input | 1 | Card clock source, synchronous to clk |
| host_cmd_n | input | 1 | Active-low host command; a falling edge activates |
| host_rst_req | input | 1 | Host card-reset request |
| card_ok | input | 1 | Card present and no external fault |
| vcc_good | input | 1 | Supply-valid comparator |
| vcc_en | output | 1 | Card supply enable |
| io_rx | output | 1 | 1 = I/O in reception, 0 = I/O held low |
| card_clk_out | output | 1 | Gated card clock |
| card_rst | output | 1 | Card reset line |
| fault_n | output | 1 | Active-low fault/absence flag to the host |

## Verification
The sequence is run in five patterns, and each one tells a different failure apart.
- A full activation with the host reset requested early shows whether the reset waits for the clock-cycle minimum or only for the stage timers.
- A command falling edge during the hold-off and another inside the discharge window separate edge acceptance from level acceptance and from the timing guards.
- A card removal partway through activation shows whether the abort takes effect at once.
- A low supply-valid shows whether the supply is cut and the fault latched on the check tick itself.
- A power event in the active state confirms that everything drops together.

Every output is compared each cycle with a tick-counting model. The model's card clock phase is not aligned with the stages, so gate timing is exercised against both clock levels.

// File: rtl/sc_power_seq.sv
module sc_power_seq #(
  parameter int unsigned HOLD_TICKS     = 10000,
  parameter int unsigned T1_TICKS       = 100,
  parameter int unsigned T2_TICKS       = 20,
  parameter int unsigned T3_TICKS       = 20,
  parameter int unsigned T4_TICKS       = 20,
  parameter int unsigned DR_TICKS       = 1,
  parameter int unsigned DC_TICKS       = 8,
  parameter int unsigned DI_TICKS       = 2,
  parameter int unsigned DISCH_TICKS    = 100,
  parameter int unsigned CLK_MIN_CYCLES = 42000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_event,
  input  logic card_clk,
  input  logic host_cmd_n,
  input  logic host_rst_req,
  input  logic card_ok,
  input  logic vcc_good,
  output logic vcc_en,
  output logic io_rx,
  output logic card_clk_out,
  output logic card_rst,
  output logic fault_n
);

  localparam int unsigned TSUM = HOLD_TICKS + T1_TICKS + T2_TICKS + T3_TICKS + T4_TICKS
                               + DR_TICKS + DC_TICKS + DI_TICKS + DISCH_TICKS;
  localparam int CW  = $clog2(TSUM + 1);
  localparam int YW  = $clog2(CLK_MIN_CYCLES + 1);

  typedef enum logic [3:0] {
    S_HOLD, S_IDLE, S_A1, S_A2, S_A3, S_A4, S_ON, S_D1, S_D2, S_D3, S_D4
  } st_t;

  st_t          state;
  logic [CW-1:0] cnt, dcnt, len;
  logic [YW-1:0] cyc;
  logic cmd_q, cclk_q, fault_r, gate_req, gate_open, vcc_r, io_r, rst_r;

  wire cyc_done  = (cyc == YW'(CLK_MIN_CYCLES));
  wire last      = tick && (cnt == len - CW'(1));
  wire deact_req = host_cmd_n || !fault_n;
  wire act_edge  = cmd_q && !host_cmd_n && fault_n;
  wire activating = (state == S_A1) || (state == S_A2) || (state == S_A3) ||
                    (state == S_A4) || (state == S_ON);

  assign fault_n      = card_ok && !fault_r;
  assign vcc_en       = vcc_r;
  assign io_rx        = io_r;
  assign card_rst     = rst_r;
  assign card_clk_out = card_clk && gate_open;

  always_comb begin
    case (state)
      S_HOLD:  len = CW'(HOLD_TICKS);
      S_A1:    len = CW'(T1_TICKS);
      S_A2:    len = CW'(T2_TICKS);
      S_A3:    len = CW'(T3_TICKS);
      S_A4:    len = CW'(T4_TICKS);
      S_D1:    len = CW'(DR_TICKS);
      S_D2:    len = CW'(DC_TICKS);
      S_D3:    len = CW'(DI_TICKS);
      default: len = CW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_HOLD; cnt <= '0; dcnt <= '0; cyc <= '0;
      cmd_q <= 1'b1; cclk_q <= 1'b0; fault_r <= 1'b0;
      gate_req <= 1'b0; gate_open <= 1'b0; vcc_r <= 1'b0; io_r <= 1'b0; rst_r <= 1'b0;
    end else if (pwr_event) begin
      state <= S_HOLD; cnt <= '0; dcnt <= '0; cyc <= '0;
      cmd_q <= 1'b1; cclk_q <= 1'b0; fault_r <= 1'b0;
      gate_req <= 1'b0; gate_open <= 1'b0; vcc_r <= 1'b0; io_r <= 1'b0; rst_r <= 1'b0;
    end else begin
      cmd_q  <= host_cmd_n;
      cclk_q <= card_clk;
      if (!card_clk) gate_open <= gate_req;
      if (!gate_req) cyc <= '0;
      else if (card_clk && !cclk_q && gate_open && !cyc_done) cyc <= cyc + YW'(1);

      if (activating && deact_req) begin
        state <= S_D1; cnt <= '0; dcnt <= '0;
      end else begin
        case (state)
          S_HOLD:
            if (tick) begin
              if (last) begin state <= S_IDLE; cnt <= '0; end
              else cnt <= cnt + CW'(1);
            end
          S_IDLE:
            if (act_edge) begin
              state <= S_A1; cnt <= '0; vcc_r <= 1'b1;
            end else if (host_cmd_n) fault_r <= 1'b0;
          S_A1, S_A2, S_A3, S_A4:
            if (tick) begin
              if (!last) cnt <= cnt + CW'(1);
              else begin
                cnt <= '0;
                case (state)
                  S_A1:
                    if (!vcc_good) begin
                      vcc_r <= 1'b0; fault_r <= 1'b1; state <= S_D1; dcnt <= '0;
                    end else state <= S_A2;
                  S_A2: begin io_r <= 1'b1; state <= S_A3; end
                  S_A3: begin gate_req <= 1'b1; state <= S_A4; end
                  default: state <= S_ON;
                endcase
              end
            end
          S_ON:
            rst_r <= host_rst_req && cyc_done;
          S_D1, S_D2, S_D3:
            if (tick) begin
              dcnt <= dcnt + CW'(1);
              if (!last) cnt <= cnt + CW'(1);
              else begin
                cnt <= '0;
                case (state)
                  S_D1: begin rst_r <= 1'b0; state <= S_D2; end
                  S_D2: begin gate_req <= 1'b0; state <= S_D3; end
                  default: begin io_r <= 1'b0; vcc_r <= 1'b0; state <= S_D4; end
                endcase
              end
            end
          S_D4:
            if (tick) begin
              if (dcnt == CW'(DISCH_TICKS - 1)) begin state <= S_IDLE; dcnt <= '0; end
              else dcnt <= dcnt + CW'(1);
            end
          default: state <= S_HOLD;
        endcase
      end
    end
  end

  a_r6_gate_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_open) |-> ($past(!card_clk) || $past(pwr_event)));
  a_r5_rst_after_min: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (gate_open && cyc_done));
  a_r2_vcc_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(state) == S_IDLE);
  a_r4_fault_cuts_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_r) |-> !vcc_en);
  a_r8_io_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    io_rx |-> vcc_en);

endmodule

// File: tb/sc_power_seq_bench.sv
`timescale 1ns/100ps
module sc_power_seq_bench;
  localparam int HOLD = 5, T1 = 3, T2 = 2, T3 = 2, T4 = 2;
  localparam int DR = 1, DC = 3, DI = 2, DISCH = 12, CMIN = 6;

  logic clk = 0, rst_n = 0, tick = 0, pwr_event = 0, card_clk = 0;
  logic host_cmd_n = 1, host_rst_req = 0, card_ok = 1, vcc_good = 1;
  logic vcc_en, io_rx, card_clk_out, card_rst, fault_n;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sc_power_seq #(.HOLD_TICKS(HOLD), .T1_TICKS(T1), .T2_TICKS(T2), .T3_TICKS(T3),
    .T4_TICKS(T4), .DR_TICKS(DR), .DC_TICKS(DC), .DI_TICKS(DI),
    .DISCH_TICKS(DISCH), .CLK_MIN_CYCLES(CMIN)) u_sc_power_seq (
    .clk, .rst_n, .tick, .pwr_event, .card_clk, .host_cmd_n, .host_rst_req,
    .card_ok, .vcc_good, .vcc_en, .io_rx, .card_clk_out, .card_rst, .fault_n);

  // stimulus for timebase and card clock
  int tc = 0, cc = 0;
  always @(posedge clk) begin
    #1;
    tc = (tc + 1) % 4; tick = (tc == 0);
    cc = (cc + 1) % 3; if (cc == 0) card_clk = ~card_clk;
  end

  // reference model: 0 hold, 1 idle, 2 activating, 3 on, 4 deactivating
  int mode = 0, t = 0, cyc = 0;
  bit e_vcc = 0, e_io = 0, e_greq = 0, e_gate = 0, e_rst = 0, e_fault = 0;
  bit cmd_q = 1, cclk_q = 0;
  always @(posedge clk) begin
    bit og, ogate;
    if (!rst_n || pwr_event) begin
      mode = 0; t = 0; cyc = 0; e_vcc = 0; e_io = 0; e_greq = 0; e_gate = 0;
      e_rst = 0; e_fault = 0; cmd_q = 1; cclk_q = 0;
    end else begin
      og = e_greq; ogate = e_gate;
      case (mode)
        0: if (tick) begin t++; if (t == HOLD) begin mode = 1; t = 0; end end
        1: if (cmd_q && !host_cmd_n && card_ok && !e_fault) begin mode = 2; t = 0; e_vcc = 1; end
           else if (host_cmd_n) e_fault = 0;
        2: if (host_cmd_n || !card_ok) begin mode = 4; t = 0; end
           else if (tick) begin
             t++;
             if (t == T1 && !vcc_good) begin e_vcc = 0; e_fault = 1; mode = 4; t = 0; end
             else begin
               if (t == T1 + T2) e_io = 1;
               if (t == T1 + T2 + T3) e_greq = 1;
               if (t == T1 + T2 + T3 + T4) mode = 3;
             end
           end
        3: if (host_cmd_n || !card_ok) begin mode = 4; t = 0; end
           else e_rst = host_rst_req && (cyc >= CMIN);
        default: if (tick) begin
             t++;
             if (t == DR) e_rst = 0;
             if (t == DR + DC) e_greq = 0;
             if (t == DR + DC + DI) begin e_io = 0; e_vcc = 0; end
             if (t == DISCH) begin mode = 1; t = 0; end
           end
      endcase
      if (!card_clk) e_gate = og;
      if (!og) cyc = 0;
      else if (card_clk && !cclk_q && ogate && cyc < CMIN) cyc++;
      cclk_q = card_clk; cmd_q = host_cmd_n;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 vcc_en", vcc_en, e_vcc);
    chk("R3 io_rx", io_rx, e_io);
    chk("R6 card_clk_out", card_clk_out, card_clk & e_gate);
    chk("R5 card_rst", card_rst, e_rst);
    chk("R10 fault_n", fault_n, card_ok & ~e_fault);
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic clks(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask
  task automatic wait_mode(int m);
    while (mode != m) @(posedge clk);
    #1;
  endtask
  task automatic activate();
    host_cmd_n = 1; clks(2); host_cmd_n = 0; clks(1);
  endtask

  initial begin
    clks(4); rst_n = 1; clks(1);
    chk("R1 reset vcc", vcc_en, 0);
    host_cmd_n = 0; clks(40);
    chk("R1 R2 no activation from hold edge or level", vcc_en, 0);
    host_rst_req = 1; activate();
    chk("R2 vcc on edge", vcc_en, 1);
    wait_mode(3); clks(60);
    chk("R5 reset after min cycles", card_rst, 1);
    host_cmd_n = 1; clks(8);
    chk("R8 reset dropped", card_rst, 0);
    clks(24);
    chk("R8 supply dropped", vcc_en, 0);
    host_cmd_n = 0; clks(4);
    chk("R9 edge in discharge ignored", vcc_en, 0);
    wait_mode(1); activate();
    chk("R2 reactivation", vcc_en, 1);
    clks(6); card_ok = 0; clks(2);
    chk("R7 abort flagged", fault_n, 0);
    wait_mode(1); clks(2);
    chk("R7 abort ends off", vcc_en, 0);
    card_ok = 1; vcc_good = 0; activate(); clks(16);
    chk("R4 fault flag", fault_n, 0);
    chk("R4 supply cut", vcc_en, 0);
    wait_mode(1); host_cmd_n = 1; clks(3);
    chk("R10 fault cleared", fault_n, 1);
    vcc_good = 1; activate(); wait_mode(3); clks(3);
    pwr_event = 1; clks(1); pwr_event = 0;
    chk("R1 power event drops supply", vcc_en, 0);
    chk("R1 power event drops io", io_rx, 0);
    activate(); clks(2);
    chk("R1 edge in hold ignored", vcc_en, 0);
    clks(10);
    finish_run();
  end
endmodule